// File: doc/BRIEF.md
# Keyed Watchdog Sequencer

This block is a 64-bit watchdog timer that software arms through a register bus. A watchdog control register carries a sticky enable bit and a 16-bit key field. The watchdog leaves its idle state only after two fixed keys are written, in order, while the global mode field selects watchdog operation. Once armed, the 64-bit counter advances on every clock and is compared with a 64-bit period. The system reset output fires when the counter reaches the period, or at once when software writes any key other than the expected one.

Software keeps an armed watchdog alive by writing the same two keys again, which clears the counter. The reset output is a registered pulse of fixed length. When the pulse ends, the watchdog returns to idle with its enable bit and counter cleared, ready to be armed again. The counter and period words can be read and written over the bus while the watchdog is not armed, and are write-protected while it is armed.

Top module: `wdg_keyed_timer`

## Requirements
- R1: After reset the reset output is low, the watchdog is idle with enable clear, and every register reads 0 (status at byte offset 0x28, mode at 0x24, counter words at 0x10 and 0x14, period words at 0x18 and 0x1C).
- R2: A write to the watchdog control register (offset 0x28; key in bits 31:16, enable in bit 14) has no effect unless the mode field (bits 3:2 at offset 0x24) holds 2.
- R3: Writing key 0xA5C6 with enable set (or already set) moves idle to pre-active, and a following write of key 0xDA7E moves pre-active to active; the status read at 0x28 shows enable in bit 14 and the state in bits 2:0 (0 idle, 1 pre-active, 2 active, 3 service pending, 4 reset pulse).
- R4: Before activation, a key written out of order (0xDA7E while idle, or any key other than 0xDA7E while pre-active) leaves the state unchanged.
- R5: The enable bit, once set, stays set through writes with bit 14 clear; only block reset or the end of a reset pulse clears it.
- R6: While armed, the counter advances by one each cycle; the first cycle in which it is at or above the period fires the reset output, so with the counter cleared the output rises period+1 cycles after the arming or servicing write.
- R7: While active or service pending, a control write carrying any key other than the expected next one (0xA5C6 when active, 0xDA7E when service pending) raises the reset output on the next cycle.
- R8: In the active state, writing 0xA5C6 and then 0xDA7E clears the counter to 0 and returns to active.
- R9: The reset output stays high for exactly 16 cycles; afterwards the state is idle, enable is clear and the counter reads 0.
- R10: Counter and period writes are ignored while armed or pulsing, and mode writes are ignored while enable is set.
- R11: When a service-completing 0xDA7E write lands on the same cycle as a timeout, the service wins and no reset pulse is produced.
- R12: Both 32-bit words of the counter and of the period are writable and read back at their offsets while the watchdog is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| sys_rst_o | output | 1 | Registered system reset pulse |

## Verification
Two functions can collide on one clock edge: a key write and a timeout. The bench places the closing 0xDA7E write exactly on the cycle where the counter reaches the period, and expects no pulse and a cleared counter. It then repeats the sequence one cycle late, where the timeout must win and the late write must be ignored. A wrong key arriving while the counter is still running is also raced against the timeout, and the behavioural model follows every edge to judge the reset output.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

   typedef enum logic [2:0] {
      WD_IDLE = 3'd0,
      WD_PRE  = 3'd1,
      WD_ACT  = 3'd2,
      WD_SVC  = 3'd3,
      WD_FIRE = 3'd4
   } wd_state_t;

   localparam logic [15:0] KEY_ARM = 16'hA5C6;
   localparam logic [15:0] KEY_GO  = 16'hDA7E;

   localparam int OFF_CNT   = 16;   // 0x10, period words follow the counter words
   localparam int OFF_GCTL  = 36;   // 0x24
   localparam int OFF_WCTL  = 40;   // 0x28

   localparam int          KEY_LSB  = 16;
   localparam int          EN_BIT   = 14;
   localparam int          MODE_LSB = 2;
   localparam logic [1:0]  MODE_WDOG = 2'd2;

endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
   import wdg_pkg::*;
#(
   parameter int BUS_W  = 32,
   parameter int ADDR_W = 6,
   parameter int NWORDS = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    we,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [BUS_W-1:0]        wdata,
   input  logic                    mode_lock,
   input  logic                    en,
   input  wd_state_t               state,
   input  logic [NWORDS*BUS_W-1:0] cnt_q,
   input  logic [NWORDS*BUS_W-1:0] prd_q,
   output logic                    mode_wd,
   output logic                    wctl_we,
   output logic [NWORDS-1:0]       cnt_we,
   output logic [NWORDS-1:0]       prd_we,
   output logic [BUS_W-1:0]        rdata
);

   localparam int OFF_PRD = OFF_CNT + 4 * NWORDS;

   logic [1:0] mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mode_q <= 2'd0;
      else if (we && addr == ADDR_W'(OFF_GCTL) && !mode_lock)
         mode_q <= wdata[MODE_LSB +: 2];
   end

   assign mode_wd = (mode_q == MODE_WDOG);
   assign wctl_we = we && (addr == ADDR_W'(OFF_WCTL));

   for (genvar g = 0; g < NWORDS; g++) begin : g_word_dec
      assign cnt_we[g] = we && (addr == ADDR_W'(OFF_CNT + 4 * g));
      assign prd_we[g] = we && (addr == ADDR_W'(OFF_PRD + 4 * g));
   end

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(OFF_GCTL))
         rdata[MODE_LSB +: 2] = mode_q;
      if (addr == ADDR_W'(OFF_WCTL)) begin
         rdata[EN_BIT] = en;
         rdata[2:0]    = state;
      end
      for (int i = 0; i < NWORDS; i++) begin
         if (addr == ADDR_W'(OFF_CNT + 4 * i))
            rdata = cnt_q[i*BUS_W +: BUS_W];
         if (addr == ADDR_W'(OFF_PRD + 4 * i))
            rdata = prd_q[i*BUS_W +: BUS_W];
      end
   end

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
   parameter int BUS_W  = 32,
   parameter int NWORDS = 2,
   localparam int CNT_W = BUS_W * NWORDS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NWORDS-1:0] cnt_we,
   input  logic [NWORDS-1:0] prd_we,
   input  logic [BUS_W-1:0]  wdata,
   input  logic              lock,
   input  logic              inc,
   input  logic              clr,
   output logic [CNT_W-1:0]  cnt_q,
   output logic [CNT_W-1:0]  prd_q,
   output logic              expired
);

   logic [BUS_W-1:0] prd_w [NWORDS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr)
         cnt_q <= '0;
      else if (inc)
         cnt_q <= cnt_q + CNT_W'(1);
      else if (!lock) begin
         for (int i = 0; i < NWORDS; i++)
            if (cnt_we[i])
               cnt_q[i*BUS_W +: BUS_W] <= wdata;
      end
   end

   for (genvar g = 0; g < NWORDS; g++) begin : g_prd
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            prd_w[g] <= '0;
         else if (prd_we[g] && !lock)
            prd_w[g] <= wdata;
      end
      assign prd_q[g*BUS_W +: BUS_W] = prd_w[g];
   end

   assign expired = (cnt_q >= prd_q);

endmodule

// File: rtl/wdg_fsm.sv
module wdg_fsm
   import wdg_pkg::*;
#(
   parameter int BUS_W     = 32,
   parameter int PULSE_LEN = 16,
   localparam int PC_W     = $clog2(PULSE_LEN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_wd,
   input  logic             wctl_we,
   input  logic [BUS_W-1:0] wdata,
   input  logic             expired,
   output wd_state_t        state,
   output logic             en,
   output logic             sys_rst,
   output logic             cnt_inc,
   output logic             cnt_clr
);

   wd_state_t        st_n;
   logic [PC_W-1:0]  pcnt;
   logic [15:0]      key;
   logic             fire;
   logic             finish;
   logic             en_n;

   assign key = wdata[KEY_LSB +: 16];

   always_comb begin
      st_n    = state;
      cnt_inc = 1'b0;
      cnt_clr = 1'b0;
      fire    = 1'b0;
      finish  = 1'b0;
      unique case (state)
         WD_IDLE: begin
            if (wctl_we && mode_wd && key == KEY_ARM && (en || wdata[EN_BIT]))
               st_n = WD_PRE;
         end
         WD_PRE: begin
            if (wctl_we && mode_wd && key == KEY_GO)
               st_n = WD_ACT;
         end
         WD_ACT: begin
            if (wctl_we) begin
               if (key == KEY_ARM) begin
                  st_n    = WD_SVC;
                  cnt_inc = !expired;
               end else
                  fire = 1'b1;
            end else if (expired)
               fire = 1'b1;
            else
               cnt_inc = 1'b1;
         end
         WD_SVC: begin
            if (wctl_we) begin
               if (key == KEY_GO) begin
                  st_n    = WD_ACT;
                  cnt_clr = 1'b1;
               end else
                  fire = 1'b1;
            end else if (expired)
               fire = 1'b1;
            else
               cnt_inc = 1'b1;
         end
         WD_FIRE: begin
            if (pcnt == '0) begin
               st_n    = WD_IDLE;
               finish  = 1'b1;
               cnt_clr = 1'b1;
            end
         end
         default: st_n = WD_IDLE;
      endcase
      if (fire)
         st_n = WD_FIRE;
   end

   always_comb begin
      en_n = en | (wctl_we && mode_wd && wdata[EN_BIT] && state != WD_FIRE);
      if (finish)
         en_n = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= WD_IDLE;
         en      <= 1'b0;
         sys_rst <= 1'b0;
         pcnt    <= '0;
      end else begin
         state <= st_n;
         en    <= en_n;
         if (fire) begin
            sys_rst <= 1'b1;
            pcnt    <= PC_W'(PULSE_LEN - 1);
         end else if (finish) begin
            sys_rst <= 1'b0;
         end else if (state == WD_FIRE) begin
            pcnt <= pcnt - PC_W'(1);
         end
      end
   end

endmodule

// File: rtl/wdg_keyed_timer.sv
module wdg_keyed_timer
   import wdg_pkg::*;
#(
   parameter int BUS_W     = 32,
   parameter int CNT_W     = 64,
   parameter int ADDR_W    = 6,
   parameter int PULSE_LEN = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              sys_rst_o
);

   localparam int NWORDS = CNT_W / BUS_W;

   if (BUS_W < 32) begin : g_bad_bus
      $error("BUS_W must hold the 16-bit key field at bits 31:16");
   end
   if (CNT_W % BUS_W != 0 || NWORDS < 1 || NWORDS > 2) begin : g_bad_cnt
      $error("CNT_W must be one or two bus words");
   end
   if (PULSE_LEN < 1) begin : g_bad_pulse
      $error("PULSE_LEN must be at least 1");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("ADDR_W must reach offset 0x28");
   end

   wd_state_t                st_q;
   logic                     en_q;
   logic                     mode_wd;
   logic                     wctl_we;
   logic [NWORDS-1:0]        cnt_we;
   logic [NWORDS-1:0]        prd_we;
   logic [NWORDS*BUS_W-1:0]  cnt_q;
   logic [NWORDS*BUS_W-1:0]  prd_q;
   logic                     expired;
   logic                     cnt_inc;
   logic                     cnt_clr;
   logic                     armed;

   assign armed = (st_q == WD_ACT) || (st_q == WD_SVC) || (st_q == WD_FIRE);

   wdg_regs #(
      .BUS_W  (BUS_W),
      .ADDR_W (ADDR_W),
      .NWORDS (NWORDS)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (bus_we),
      .addr      (bus_addr),
      .wdata     (bus_wdata),
      .mode_lock (en_q),
      .en        (en_q),
      .state     (st_q),
      .cnt_q     (cnt_q),
      .prd_q     (prd_q),
      .mode_wd   (mode_wd),
      .wctl_we   (wctl_we),
      .cnt_we    (cnt_we),
      .prd_we    (prd_we),
      .rdata     (bus_rdata)
   );

   wdg_counter #(
      .BUS_W  (BUS_W),
      .NWORDS (NWORDS)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .cnt_we  (cnt_we),
      .prd_we  (prd_we),
      .wdata   (bus_wdata),
      .lock    (armed),
      .inc     (cnt_inc),
      .clr     (cnt_clr),
      .cnt_q   (cnt_q),
      .prd_q   (prd_q),
      .expired (expired)
   );

   wdg_fsm #(
      .BUS_W     (BUS_W),
      .PULSE_LEN (PULSE_LEN)
   ) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode_wd (mode_wd),
      .wctl_we (wctl_we),
      .wdata   (bus_wdata),
      .expired (expired),
      .state   (st_q),
      .en      (en_q),
      .sys_rst (sys_rst_o),
      .cnt_inc (cnt_inc),
      .cnt_clr (cnt_clr)
   );

endmodule

// File: rtl/wdg_chk.sv
module wdg_chk #(
   parameter int BUS_W     = 32,
   parameter int CNT_W     = 64,
   parameter int ADDR_W    = 6,
   parameter int PULSE_LEN = 16,
   localparam int HL_W     = $clog2(PULSE_LEN + 2)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              we,
   input logic [ADDR_W-1:0] addr,
   input logic [BUS_W-1:0]  wdata,
   input logic              sys_rst,
   input logic [2:0]        st,
   input logic              en,
   input logic [CNT_W-1:0]  prd
);

   logic [HL_W-1:0] hi_len;
   logic            wctl_wr;
   logic            prd_wr;
   logic [15:0]     key;

   assign key     = wdata[31:16];
   assign wctl_wr = we && addr == ADDR_W'(40);
   assign prd_wr  = we && addr == ADDR_W'(16 + 4 * (CNT_W / BUS_W));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hi_len <= '0;
      else if (!sys_rst)
         hi_len <= '0;
      else if (hi_len != {HL_W{1'b1}})
         hi_len <= hi_len + HL_W'(1);
   end

   assert_pulse_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sys_rst) |-> hi_len == HL_W'(PULSE_LEN));

   assert_pulse_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst |-> hi_len < HL_W'(PULSE_LEN));

   assert_bad_key_fires_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wctl_wr && st == 3'd2 && key != 16'hA5C6) |=> sys_rst);

   assert_idle_ignores_go_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wctl_wr && st == 3'd0 && key == 16'hDA7E) |=> st == 3'd0);

   assert_en_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && st != 3'd4) |=> en);

   assert_prd_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (prd_wr && (st == 3'd2 || st == 3'd3)) |=> $stable(prd));

   assert_rst_from_armed_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sys_rst) |-> ($past(st) == 3'd2 || $past(st) == 3'd3));

endmodule

bind wdg_keyed_timer wdg_chk #(
   .BUS_W     (BUS_W),
   .CNT_W     (CNT_W),
   .ADDR_W    (ADDR_W),
   .PULSE_LEN (PULSE_LEN)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .we      (bus_we),
   .addr    (bus_addr),
   .wdata   (bus_wdata),
   .sys_rst (sys_rst_o),
   .st      (st_q),
   .en      (en_q),
   .prd     (prd_q)
);

// File: tb/sim_wdg_keyed_timer.sv
`timescale 1ns/1ps
module sim_wdg_keyed_timer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        sys_rst_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2.5 clk = ~clk;

   wdg_keyed_timer u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .sys_rst_o (sys_rst_o)
   );

   // behavioural reference model
   int              m_st;
   bit              m_en;
   bit [1:0]        m_mode;
   longint unsigned m_cnt, m_prd;
   int              m_pc;
   bit              m_rst;

   always @(posedge clk or negedge rst_n) begin
      bit [15:0]       k;
      bit              wc, md, armed, expd, fire;
      int              nst, npc;
      bit              nen, nrst;
      bit [1:0]        nmode;
      longint unsigned ncnt, nprd;
      if (!rst_n) begin
         m_st = 0; m_en = 0; m_mode = 0; m_cnt = 0; m_prd = 0; m_pc = 0; m_rst = 0;
      end else begin
         k = bus_wdata[31:16];
         wc = bus_we && bus_addr == 6'h28;
         md = (m_mode == 2'd2);
         armed = (m_st >= 2);
         expd = (m_cnt >= m_prd);
         fire = 0;
         nst = m_st; npc = m_pc; nen = m_en; nrst = m_rst;
         nmode = m_mode; ncnt = m_cnt; nprd = m_prd;
         if (bus_we && !armed) begin
            if (bus_addr == 6'h10) ncnt[31:0]  = bus_wdata;
            if (bus_addr == 6'h14) ncnt[63:32] = bus_wdata;
            if (bus_addr == 6'h18) nprd[31:0]  = bus_wdata;
            if (bus_addr == 6'h1C) nprd[63:32] = bus_wdata;
         end
         if (bus_we && bus_addr == 6'h24 && !m_en) nmode = bus_wdata[3:2];
         if (wc && md && bus_wdata[14] && m_st != 4) nen = 1;
         case (m_st)
            0: if (wc && md && k == 16'hA5C6 && (m_en || bus_wdata[14])) nst = 1;
            1: if (wc && md && k == 16'hDA7E) nst = 2;
            2: begin
               if (wc) begin
                  if (k == 16'hA5C6) begin nst = 3; if (!expd) ncnt = m_cnt + 1; end
                  else fire = 1;
               end else if (expd) fire = 1;
               else ncnt = m_cnt + 1;
            end
            3: begin
               if (wc) begin
                  if (k == 16'hDA7E) begin nst = 2; ncnt = 0; end
                  else fire = 1;
               end else if (expd) fire = 1;
               else ncnt = m_cnt + 1;
            end
            default: begin
               if (m_pc == 0) begin nst = 0; nen = 0; ncnt = 0; nrst = 0; end
               else npc = m_pc - 1;
            end
         endcase
         if (fire) begin nst = 4; npc = 15; nrst = 1; end
         m_st = nst; m_pc = npc; m_en = nen; m_rst = nrst;
         m_mode = nmode; m_cnt = ncnt; m_prd = nprd;
      end
   end

   // per-cycle comparison of the reset output (R6 R7 R9 R11)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         n_tests++;
         if (sys_rst_o !== m_rst) begin
            n_fail++;
            $display("FAIL R9 model compare t=%0t sys_rst actual=%0b expected=%0b", $time, sys_rst_o, m_rst);
         end
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [5:0] a, input string tag, input logic [31:0] exp);
      bus_addr = a;
      #1;
      chk(tag, 64'(bus_rdata), 64'(exp));
   endtask

   task automatic arm(input longint unsigned prd);
      wr(6'h10, 32'h0); wr(6'h14, 32'h0);
      wr(6'h18, prd[31:0]); wr(6'h1C, prd[63:32]);
      wr(6'h28, 32'hA5C6_4000);
      wr(6'h28, 32'hDA7E_4000);
   endtask

   task automatic wait_pulse_end();
      while (sys_rst_o) @(negedge clk);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int k;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 sys_rst", 64'(sys_rst_o), 64'd0);
      rd(6'h28, "R1 status", 32'h0);
      rd(6'h24, "R1 mode", 32'h0);
      rd(6'h10, "R1 cnt lo", 32'h0);
      rd(6'h1C, "R1 prd hi", 32'h0);
      // R2 mode not selected: control write ignored
      wr(6'h28, 32'hA5C6_4000);
      rd(6'h28, "R2 ignored", 32'h0);
      // R12 word readback while idle
      wr(6'h14, 32'hDEAD_0001);
      wr(6'h18, 32'h1234_5678);
      rd(6'h14, "R12 cnt hi", 32'hDEAD_0001);
      rd(6'h18, "R12 prd lo", 32'h1234_5678);
      // select watchdog mode
      wr(6'h24, 32'h8);
      rd(6'h24, "R2 mode", 32'h8);
      // R4 go key while idle: still idle, enable set
      wr(6'h28, 32'hDA7E_4000);
      rd(6'h28, "R4 idle go", 32'h0000_4000);
      // R10 mode locked while enabled
      wr(6'h24, 32'h0);
      rd(6'h24, "R10 mode lock", 32'h8);
      // R5 enable sticky
      wr(6'h28, 32'h0);
      rd(6'h28, "R5 sticky", 32'h0000_4000);
      // R3 to pre-active, then R4 wrong key in pre-active
      wr(6'h28, 32'hA5C6_0000);
      rd(6'h28, "R3 pre", 32'h0000_4001);
      wr(6'h28, 32'h1234_4000);
      rd(6'h28, "R4 pre hold", 32'h0000_4001);
      wr(6'h10, 32'h0); wr(6'h14, 32'h0);
      wr(6'h18, 32'd20); wr(6'h1C, 32'h0);
      wr(6'h28, 32'hDA7E_4000);
      rd(6'h28, "R3 active", 32'h0000_4002);
      repeat (4) @(negedge clk);
      rd(6'h10, "R6 count", 32'(m_cnt));
      // R10 period and counter locked while armed
      wr(6'h18, 32'd5000);
      rd(6'h18, "R10 prd lock", 32'd20);
      wr(6'h10, 32'hFFFF_0000);
      rd(6'h10, "R10 cnt lock", 32'(m_cnt));
      // R8 service
      wr(6'h28, 32'hA5C6_4000);
      rd(6'h28, "R8 svc pend", 32'h0000_4003);
      wr(6'h28, 32'hDA7E_4000);
      rd(6'h10, "R8 cleared", 32'h0);
      rd(6'h28, "R8 back active", 32'h0000_4002);
      // R6 timeout latency period+1
      k = 0;
      while (!sys_rst_o) begin @(negedge clk); k++; end
      chk("R6 latency", 64'(k), 64'd21);
      rd(6'h28, "R6 firing", 32'h0000_4004);
      // R9 pulse width and aftermath
      k = 0;
      while (sys_rst_o) begin @(negedge clk); k++; end
      chk("R9 width", 64'(k), 64'd16);
      rd(6'h28, "R9 idle", 32'h0);
      rd(6'h10, "R9 cnt", 32'h0);
      // R7 wrong key while active
      arm(64'd1000);
      wr(6'h28, 32'h0000_4000);
      chk("R7 active wrong key", 64'(sys_rst_o), 64'd1);
      wait_pulse_end();
      // R7 wrong key while service pending
      arm(64'd1000);
      wr(6'h28, 32'hA5C6_4000);
      wr(6'h28, 32'hA5C6_4000);
      chk("R7 svc wrong key", 64'(sys_rst_o), 64'd1);
      wait_pulse_end();
      // R11 service lands on the timeout cycle
      arm(64'd10);
      wr(6'h28, 32'hA5C6_4000);
      repeat (9) @(negedge clk);
      wr(6'h28, 32'hDA7E_4000);
      chk("R11 svc wins rst", 64'(sys_rst_o), 64'd0);
      rd(6'h10, "R11 svc wins cnt", 32'h0);
      // R11 one cycle late: timeout wins
      wr(6'h28, 32'hA5C6_4000);
      repeat (10) @(negedge clk);
      wr(6'h28, 32'hDA7E_4000);
      chk("R11 late fires", 64'(sys_rst_o), 64'd1);
      rd(6'h28, "R11 late state", 32'h0000_4004);
      wait_pulse_end();
      // R6 zero period fires almost at once
      arm(64'd0);
      @(negedge clk);
      chk("R6 zero period", 64'(sys_rst_o), 64'd1);
      wait_pulse_end();
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule